// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block behaves as a small serial memory device of 64 words by 16 bits, seen from a host through a chip select, a shift clock, a serial data input and a serial data output with an output enable. The shift clock and the data pins are sampled by the system clock, so the block sits inside a synchronous design and the host's shift clock must be several system clocks per phase. Every transaction is a frame opened by raising chip select. The frame carries a start bit, a two-bit command code and a six-bit word address, and for the two writing commands sixteen data bits follow.

Commands read one word, write one word, erase one word to all ones, write one value to every word, erase every word, and set or clear a write-permission latch. Commands that change the memory take effect only while that latch is set. A change starts a self-timed programming interval whose length is a parameter in system clocks. When chip select is raised again after the change has started, the data output shows a busy level and then a ready level. While the interval runs, the block accepts no command. The storage is a register array that comes out of reset holding all ones.

The serial pins are plain levels with no handshake. There is no back-pressure path: the host must finish each frame and wait for the ready level before it sends the next command that changes memory.

Top module: `mw_serial_eeprom`

## Requirements
- R1: After reset, every word reads 16'hFFFF, the write-permission latch is clear and `dout_oe` is 0.
- R2: `dout_oe` is 0 whenever `cs` is low, including when `cs` falls in the middle of a read.
- R3: `din` is sampled on rising `sk` while `cs` is high. Zeros before the first 1 are skipped. That 1 is the start bit, and it is followed by a 2-bit code and then a 6-bit address, each sent MSB first.
- R4: Code 10 (read) drives `dout` = 0 after the rising edge that takes the last address bit. The next 16 rising edges then put out the addressed word, MSB first. Reading works whether the latch is set or clear.
- R5: Code 00 with address bits [5:4] = 11 sets the latch, and code 00 with [5:4] = 00 clears it. While the latch is clear, no command changes any word.
- R6: Code 01 (write) takes 16 data bits, MSB first, after the address. With the latch set, the addressed word takes that value once `cs` falls after the last data bit.
- R7: Code 11 (erase) sets the addressed word to 16'hFFFF when `cs` falls after the address, provided the latch is set.
- R8: Code 00 with [5:4] = 01 takes 16 data bits and writes that value to all 64 words.
- R9: Code 00 with [5:4] = 10 sets all 64 words to 16'hFFFF.
- R10: Each change begins a programming interval of `WRITE_CYCLES` clocks. With `cs` high and no start bit yet taken, `dout_oe` is 1 and `dout` reads 0 while the interval runs and 1 once it ends. This status output lasts until the next start bit is taken.
- R11: During the programming interval, the data bits on `din` are ignored and no frame is decoded.
- R12: If a frame that writes ends, by `cs` falling, before its last bit arrives, it changes nothing and starts no programming interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, high frames a command |
| sk | input | 1 | Host shift clock, sampled by `clk` |
| din | input | 1 | Serial command, address and data input |
| dout | output | 1 | Serial data or ready/busy level |
| dout_oe | output | 1 | Output enable for `dout`; 0 means high impedance |

## Verification
Errors in the internal state show up at the data output within a frame or two. A frame decoder that slips by a bit shows up on the next read as a shifted word or a missing leading 0. A wrong permission latch shows up as a word that changes, or fails to change, when the following read returns it. A wrong programming timer shows up at the moment `cs` is raised again: the busy or ready level is wrong, or it switches earlier or later than `WRITE_CYCLES` allows. A decoder that listens while busy shows up as read data in place of the busy level.

// File: rtl/mwe_pkg.sv
package mwe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_DATA,
    ST_READ,
    ST_DONE
  } frame_st_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_ERASE,
    CMD_WRALL,
    CMD_ERALL
  } wcmd_t;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_WRALL  = 2'b01;
  localparam logic [1:0] SUB_ERALL  = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;

endpackage

// File: rtl/mwe_pin_sync.sv
module mwe_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic cs_q,
  output logic di_q,
  output logic sk_rise,
  output logic cs_fall
);

  logic sk_q, sk_p, cs_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sk_q <= 1'b0;
      di_q <= 1'b0;
      sk_p <= 1'b0;
      cs_p <= 1'b0;
    end else begin
      cs_q <= cs;
      sk_q <= sk;
      di_q <= din;
      sk_p <= sk_q;
      cs_p <= cs_q;
    end
  end

  assign sk_rise = sk_q & ~sk_p;
  assign cs_fall = cs_p & ~cs_q;

endmodule

// File: rtl/mwe_write_timer.sv
module mwe_write_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/mwe_frame_decoder.sv
module mwe_frame_decoder
  import mwe_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_q,
  input  logic          cs_fall,
  input  logic          sk_rise,
  input  logic          di_q,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          fire,
  output wcmd_t         fire_cmd,
  output logic [AW-1:0] fire_addr,
  output logic [DW-1:0] fire_data,
  output logic          set_wen,
  output logic          clr_wen,
  output logic          drv,
  output logic          drv_val,
  output logic          frame_active
);

  localparam int HW   = AW + 2;
  localparam int CMAX = (DW > HW) ? DW : HW;
  localparam int CW   = $clog2(CMAX + 1);

  frame_st_t     st;
  wcmd_t         pend;
  logic [HW-1:0] hdr;
  logic [HW-1:0] hdr_nx;
  logic [CW-1:0] cnt;
  logic [DW-1:0] dsh;
  logic [DW-1:0] rsh;

  assign hdr_nx       = {hdr[HW-2:0], di_q};
  assign rd_addr      = hdr_nx[AW-1:0];
  assign fire         = cs_fall && (st == ST_DONE) && (pend != CMD_NONE);
  assign fire_cmd     = pend;
  assign fire_addr    = hdr[AW-1:0];
  assign fire_data    = dsh;
  assign frame_active = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pend    <= CMD_NONE;
      hdr     <= '0;
      cnt     <= '0;
      dsh     <= '0;
      rsh     <= '0;
      drv     <= 1'b0;
      drv_val <= 1'b0;
      set_wen <= 1'b0;
      clr_wen <= 1'b0;
    end else begin
      set_wen <= 1'b0;
      clr_wen <= 1'b0;
      if (!cs_q) begin
        st      <= ST_IDLE;
        pend    <= CMD_NONE;
        cnt     <= '0;
        drv     <= 1'b0;
        drv_val <= 1'b0;
      end else if (sk_rise && !busy) begin
        case (st)
          ST_IDLE: begin
            if (di_q) begin
              st  <= ST_HEAD;
              cnt <= '0;
            end
          end
          ST_HEAD: begin
            hdr <= hdr_nx;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HW - 1)) begin
              cnt <= '0;
              case (hdr_nx[HW-1:HW-2])
                OP_READ: begin
                  rsh     <= rd_word;
                  drv     <= 1'b1;
                  drv_val <= 1'b0;
                  st      <= ST_READ;
                end
                OP_WRITE: begin
                  pend <= CMD_WRITE;
                  st   <= ST_DATA;
                end
                OP_ERASE: begin
                  pend <= CMD_ERASE;
                  st   <= ST_DONE;
                end
                default: begin
                  case (hdr_nx[AW-1:AW-2])
                    SUB_UNLOCK: begin
                      set_wen <= 1'b1;
                      st      <= ST_DONE;
                    end
                    SUB_LOCK: begin
                      clr_wen <= 1'b1;
                      st      <= ST_DONE;
                    end
                    SUB_WRALL: begin
                      pend <= CMD_WRALL;
                      st   <= ST_DATA;
                    end
                    default: begin
                      pend <= CMD_ERALL;
                      st   <= ST_DONE;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            dsh <= {dsh[DW-2:0], di_q};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) st <= ST_DONE;
          end
          ST_READ: begin
            if (cnt == CW'(DW)) begin
              drv <= 1'b0;
              st  <= ST_DONE;
            end else begin
              drv_val <= rsh[DW-1];
              rsh     <= {rsh[DW-2:0], 1'b0};
              cnt     <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/mw_serial_eeprom.sv
module mw_serial_eeprom
  import mwe_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic din,
  output logic dout,
  output logic dout_oe
);

  localparam int WORDS = 1 << ADDR_W;

  logic              cs_q, di_q, sk_rise, cs_fall;
  logic [ADDR_W-1:0] rd_addr, fire_addr;
  logic [DATA_W-1:0] fire_data;
  wcmd_t             fire_cmd;
  logic              fire, set_wen, clr_wen, drv, drv_val, frame_active;
  logic              wen, start, wr_busy, stat_pend;
  logic [DATA_W-1:0] mem [WORDS];

  mwe_pin_sync sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .din     (din),
    .cs_q    (cs_q),
    .di_q    (di_q),
    .sk_rise (sk_rise),
    .cs_fall (cs_fall)
  );

  mwe_frame_decoder #(.AW(ADDR_W), .DW(DATA_W)) dec_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_q         (cs_q),
    .cs_fall      (cs_fall),
    .sk_rise      (sk_rise),
    .di_q         (di_q),
    .busy         (wr_busy),
    .rd_word      (mem[rd_addr]),
    .rd_addr      (rd_addr),
    .fire         (fire),
    .fire_cmd     (fire_cmd),
    .fire_addr    (fire_addr),
    .fire_data    (fire_data),
    .set_wen      (set_wen),
    .clr_wen      (clr_wen),
    .drv          (drv),
    .drv_val      (drv_val),
    .frame_active (frame_active)
  );

  mwe_write_timer #(.CYCLES(WRITE_CYCLES)) tmr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (wr_busy)
  );

  assign start = fire & wen;

  always_ff @(posedge clk) begin
    if (!rst_n) wen <= 1'b0;
    else if (set_wen) wen <= 1'b1;
    else if (clr_wen) wen <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (start) begin
      case (fire_cmd)
        CMD_WRITE: mem[fire_addr] <= fire_data;
        CMD_ERASE: mem[fire_addr] <= '1;
        CMD_WRALL: for (int i = 0; i < WORDS; i++) mem[i] <= fire_data;
        CMD_ERALL: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_pend <= 1'b0;
    else if (start) stat_pend <= 1'b1;
    else if (frame_active) stat_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= cs_q & (drv | (stat_pend & ~frame_active));
      dout    <= drv ? drv_val : (stat_pend & ~wr_busy);
    end
  end

endmodule

// File: rtl/mwe_checker.sv
module mwe_checker #(
  parameter int WRITE_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_q,
  input logic dout_oe,
  input logic wr_busy,
  input logic wen,
  input logic set_wen,
  input logic clr_wen,
  input logic frame_active
);

  int busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= 0;
    else if (wr_busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  p_hiz_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> !dout_oe);

  p_unlock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_wen |=> wen);

  p_lock_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wen |=> !wen);

  p_change_needs_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_busy) |-> $past(wen));

  p_busy_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> (busy_len < WRITE_CYCLES));

  p_deaf_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !frame_active);

endmodule

bind mw_serial_eeprom mwe_checker #(.WRITE_CYCLES(WRITE_CYCLES)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_q         (cs_q),
  .dout_oe      (dout_oe),
  .wr_busy      (wr_busy),
  .wen          (wen),
  .set_wen      (set_wen),
  .clr_wen      (clr_wen),
  .frame_active (frame_active)
);

// File: tb/mw_serial_eeprom_tb.sv
module mw_serial_eeprom_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WC         = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, din = 1'b0;
  logic dout, dout_oe;
  logic smp_o, smp_oe;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;

  logic [15:0] mem_m [64];
  bit          wen_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mw_serial_eeprom #(.ADDR_W(6), .DATA_W(16), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cs_set(input logic v);
    cs = v;
    tick(4);
  endtask

  task automatic clk_bit(input logic b);
    din = b;
    tick(4);
    sk = 1'b1;
    tick(4);
    smp_o  = dout;
    smp_oe = dout_oe;
    sk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i]);
  endtask

  task automatic read_word(input int a, input string r);
    logic [15:0] w = '0;
    bit oe_all = 1'b1;
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b10, 6'(a)}, 9);
    chk({r, " dummy zero"}, {smp_oe, smp_o}, 2'b10);
    for (int i = 0; i < 16; i++) begin
      clk_bit(1'b0);
      w = {w[14:0], smp_o};
      oe_all = oe_all & smp_oe;
    end
    chk({r, " read word"}, w, mem_m[a]);
    chk({r, " read enable"}, oe_all, 1);
    cs_set(1'b0);
  endtask

  task automatic wait_ready(input string r);
    int n = 0;
    cs_set(1'b1);
    while (!(dout_oe && dout) && n < 2 * WC) begin
      tick(1);
      n++;
    end
    chk({r, " ready reached"}, {dout_oe, dout}, 2'b11);
    cs_set(1'b0);
  endtask

  task automatic special(input logic [1:0] sub);
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b00, sub, 4'b0000}, 9);
    cs_set(1'b0);
    if (sub == 2'b11) wen_m = 1'b1;
    if (sub == 2'b00) wen_m = 1'b0;
  endtask

  task automatic write_word(input int a, input logic [15:0] d);
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b01, 6'(a)}, 9);
    send({16'd0, d}, 16);
    cs_set(1'b0);
    if (wen_m) begin
      mem_m[a] = d;
      wait_ready("R6");
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    wen_m = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R1 / R2: output idle after reset
    chk("R1 reset oe", dout_oe, 0);
    cs_set(1'b1);
    chk("R2 idle cs high, no status", dout_oe, 0);
    cs_set(1'b0);
    read_word(5, "R1");
    read_word(63, "R1");

    // R5 / R6: write while locked has no effect, no status shown
    write_word(5, 16'h1234);
    cs_set(1'b1);
    chk("R5 locked write no busy", dout_oe, 0);
    cs_set(1'b0);
    read_word(5, "R5");

    // R3, R6, R10: unlock, write with leading zeros, timed status
    special(2'b11);
    cs_set(1'b1);
    send(32'd0, 3);
    send({23'd0, 1'b1, 2'b01, 6'd5}, 9);
    send({16'd0, 16'hA5C3}, 16);
    cs_set(1'b0);
    mem_m[5] = 16'hA5C3;
    cs_set(1'b1);
    chk("R10 busy level", {dout_oe, dout}, 2'b10);
    tick(WC - 30);
    chk("R10 still busy", {dout_oe, dout}, 2'b10);
    tick(40);
    chk("R10 ready level", {dout_oe, dout}, 2'b11);
    cs_set(1'b0);
    read_word(5, "R3");
    read_word(6, "R4");

    // R11: frame during programming is ignored, busy level persists
    write_word(9, 16'h0F0F);
    write_word(10, 16'h1111);
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b01, 6'd10}, 9);
    send({16'd0, 16'h2222}, 16);
    cs_set(1'b0);
    mem_m[10] = 16'h2222;
    cs_set(1'b1);
    begin
      bit all_busy = 1'b1;
      for (int i = 0; i < 13; i++) begin
        clk_bit(i < 1 || i == 1 ? 1'b1 : 1'b0);
        all_busy = all_busy & smp_oe & ~smp_o;
      end
      chk("R11 busy holds over ignored frame", all_busy, 1);
    end
    cs_set(1'b0);
    wait_ready("R11");
    read_word(10, "R11");
    read_word(9, "R6");

    // R7: erase one word
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b11, 6'd9}, 9);
    cs_set(1'b0);
    mem_m[9] = 16'hFFFF;
    wait_ready("R7");
    read_word(9, "R7");

    // boundary address and R12 truncated write
    write_word(63, 16'h8001);
    read_word(63, "R6");
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b01, 6'd63}, 9);
    send(32'h0000_00AA, 8);
    cs_set(1'b0);
    cs_set(1'b1);
    chk("R12 truncated no status", dout_oe, 0);
    cs_set(1'b0);
    read_word(63, "R12");

    // R2: cs dropped mid-read
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b10, 6'd5}, 9);
    send(32'd0, 4);
    chk("R2 driving mid-read", smp_oe, 1);
    cs = 1'b0;
    tick(4);
    chk("R2 hiz after cs low", dout_oe, 0);

    // R8: write all
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b00, 2'b01, 4'b0000}, 9);
    send({16'd0, 16'h3C3C}, 16);
    cs_set(1'b0);
    for (int i = 0; i < 64; i++) mem_m[i] = 16'h3C3C;
    wait_ready("R8");
    read_word(0, "R8");
    read_word(63, "R8");

    // R5: lock then erase-all is ignored; read still works
    special(2'b00);
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b00, 2'b10, 4'b0000}, 9);
    cs_set(1'b0);
    cs_set(1'b1);
    chk("R5 locked erase-all no status", dout_oe, 0);
    cs_set(1'b0);
    read_word(0, "R4 locked read");

    // R9: erase all
    special(2'b11);
    cs_set(1'b1);
    send({23'd0, 1'b1, 2'b00, 2'b10, 4'b0000}, 9);
    cs_set(1'b0);
    for (int i = 0; i < 64; i++) mem_m[i] = 16'hFFFF;
    wait_ready("R9");
    read_word(0, "R9");
    read_word(40, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule